// File: doc/BRIEF.md
# Zero-Turnaround Late-Write Synchronous SRAM

This block is a small synchronous static memory that takes a new read or write command on every clock edge, in any order, with no idle cycle when the direction of the data bus changes. It can do this because write data does not travel with its address. The data follows the address by the same number of cycles that read data takes to come back. The bus therefore carries one data word per cycle whatever the mix of reads and writes.

A static mode input picks one of two timings. In registered-output mode, read data passes through an output register: it is valid after the second edge following the command, and write data is sampled two edges after its address. In flow-through mode, the read data comes straight from the array after the command edge, and write data is sampled one edge after its address.

Other controls:
- A load command can start a four-beat burst, which later step commands walk in either linear or XOR order.
- Writes are byte-granular.
- Three chip selects must all be active for a load to be accepted.
- An output enable and a sleep input both gate the output drive asynchronously.
- A read that lands on a word whose write data has not yet been committed is served from the incoming write, merged byte by byte with the stored word.

Top module: `lwsram`

## Requirements
- R1: In registered-output mode (`flow_thru`=0), a read accepted on edge k drives its word on `dout` with `dout_drv`=1 after edge k+1 and until edge k+2. After edge k, `dout_drv` stays 0 unless an earlier read is due.
- R2: In flow-through mode (`flow_thru`=1), a read accepted on edge k drives its word with `dout_drv`=1 after edge k and until edge k+1. The cycle before that stays undriven after idle cycles.
- R3: The data of a write accepted on edge k is sampled from `din` on edge k+2 in registered-output mode and on edge k+1 in flow-through mode.
- R4: Reads and writes may follow one another on consecutive edges in any order. A read returns the word as left by every write accepted before it, including writes whose data has not yet been committed to the array.
- R5: Byte lane i is bits [9i+8:9i]. A write changes lane i only when `byte_wr_n[i]` is 0 on the command edge, and leaves the other lanes unchanged.
- R6: A load (`burst_step`=0) is accepted only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Otherwise it is a no-operation: nothing is written and nothing is driven.
- R7: A step command (`burst_step`=1) repeats the operation of the last accepted load at the next beat address, and ignores `addr` and `wr_n`. A step after a deselected load, an idle cycle or a sleep cycle does nothing.
- R8: With `order_xor`=0, beat n of a burst uses low address bits (base+n) mod 4. The upper address bits stay those of the load.
- R9: With `order_xor`=1, beat n of a burst uses low address bits base XOR n.
- R10: While `out_en_n`=1, `dout_drv`=0 and `dout`=0 immediately, whatever reads are in flight.
- R11: While `sleep_req`=1, the output is undriven. Commands sampled on such an edge are ignored and any burst in progress ends.
- R12: Reset is synchronous and active low. It empties the command pipeline so that `dout_drv`=0, and it leaves the array contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flow_thru | input | 1 | Static timing mode: 1 flow-through, 0 registered output |
| order_xor | input | 1 | Static burst order: 1 XOR order, 0 linear |
| addr | input | ADDR_W | Word address, sampled on load |
| wr_n | input | 1 | Load direction: 0 write, 1 read |
| byte_wr_n | input | NBYTES | Active-low byte write enables, sampled with each write beat |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| burst_step | input | 1 | 1 steps the current burst, 0 loads a new command |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| sleep_req | input | 1 | Power-down request; blocks commands and output |
| din | input | NBYTES*BYTE_W | Write data, delayed per R3 |
| dout | output | NBYTES*BYTE_W | Read data, zero when not driven |
| dout_drv | output | 1 | High when `dout` carries read data |

## Verification
A missed match between the read stage and the pending write stage shows up at the registered-output read of a word rewritten one cycle earlier. The stale byte lanes appear on `dout` on the very cycle that read is due. A wrong burst counter or order puts a beat's data at a neighbouring word, and this shows on the single-word read-back a few cycles after the burst. A pipeline stage that survives reset, sleep or a deselected load raises `dout_drv` in a cycle where the bench expects no drive, within one or two edges of the fault.

// File: rtl/lwsram_pkg.sv
`timescale 1ns/1ps
// lwsram_pkg: shared helpers for the late-write SRAM.
// Assumes bursts are four beats, so beat offsets are two bits wide.
package lwsram_pkg;

    localparam int BEAT_W = 2;

    // Low address bits of a burst beat from its base and beat number.
    function automatic logic [BEAT_W-1:0] beat_lo(
        input logic [BEAT_W-1:0] base,
        input logic [BEAT_W-1:0] n,
        input logic              use_xor
    );
        return use_xor ? (base ^ n) : (base + n);
    endfunction

endpackage

// File: rtl/lwsram_cmd.sv
`timescale 1ns/1ps
// lwsram_cmd: turns the pins sampled on each edge into one effective
// command (valid, direction, word address, byte enables).
// Keeps the burst state of the last accepted load.
// Assumes ADDR_W >= 2 and that order_xor is static.
module lwsram_cmd
    import lwsram_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int NBYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_req,
    input  logic              order_xor,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_n,
    input  logic [NBYTES-1:0] byte_wr_n,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              burst_step,
    output logic              cmd_v,
    output logic              cmd_wr,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [NBYTES-1:0] cmd_be
);

    localparam int HI_W = ADDR_W - BEAT_W;

    logic              selected;
    logic              b_act;
    logic              b_wr;
    logic [ADDR_W-1:0] b_base;
    logic [BEAT_W-1:0] b_cnt;
    logic [BEAT_W-1:0] next_cnt;

    assign selected = ~sel_a_n & sel_b & ~sel_c_n;
    assign next_cnt = b_cnt + 1'b1;

    // Effective command for this edge: load, burst step or nothing.
    always_comb begin
        cmd_v    = 1'b0;
        cmd_wr   = 1'b0;
        cmd_addr = addr;
        cmd_be   = ~byte_wr_n;
        if (!sleep_req) begin
            if (!burst_step) begin
                cmd_v  = selected;
                cmd_wr = ~wr_n;
            end else begin
                cmd_v    = b_act;
                cmd_wr   = b_wr;
                cmd_addr = {b_base[ADDR_W-1 -: HI_W],
                            beat_lo(b_base[BEAT_W-1:0], next_cnt, order_xor)};
            end
        end
    end

    // Burst state: captured by a load, stepped by an advance, ended by sleep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_act  <= 1'b0;
            b_wr   <= 1'b0;
            b_base <= '0;
            b_cnt  <= '0;
        end else if (sleep_req) begin
            b_act <= 1'b0;
        end else if (!burst_step) begin
            b_act  <= selected;
            b_wr   <= ~wr_n;
            b_base <= addr;
            b_cnt  <= '0;
        end else if (b_act) begin
            b_cnt <= next_cnt;
        end
    end

endmodule

// File: rtl/lwsram_stages.sv
`timescale 1ns/1ps
// lwsram_stages: shift register of accepted commands.
// Stage 0 holds the command taken on the last edge, stage 1 the one before.
// Assumes STAGES >= 2.
module lwsram_stages #(
    parameter int ADDR_W = 5,
    parameter int NBYTES = 2,
    parameter int STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_v,
    input  logic                          in_wr,
    input  logic [ADDR_W-1:0]             in_addr,
    input  logic [NBYTES-1:0]             in_be,
    output logic [STAGES-1:0]             st_v,
    output logic [STAGES-1:0]             st_wr,
    output logic [STAGES-1:0][ADDR_W-1:0] st_addr,
    output logic [STAGES-1:0][NBYTES-1:0] st_be
);

    // Advance every command one stage per edge; reset empties the pipe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_v    <= '0;
            st_wr   <= '0;
            st_addr <= '0;
            st_be   <= '0;
        end else begin
            st_v[0]    <= in_v;
            st_wr[0]   <= in_wr;
            st_addr[0] <= in_addr;
            st_be[0]   <= in_be;
            for (int i = 1; i < STAGES; i++) begin
                st_v[i]    <= st_v[i-1];
                st_wr[i]   <= st_wr[i-1];
                st_addr[i] <= st_addr[i-1];
                st_be[i]   <= st_be[i-1];
            end
        end
    end

endmodule

// File: rtl/lwsram_array.sv
`timescale 1ns/1ps
// lwsram_array: word array split into byte lanes, one write port and one
// asynchronous read port. Not reset: contents survive reset.
module lwsram_array #(
    parameter int ADDR_W = 5,
    parameter int NBYTES = 2,
    parameter int BYTE_W = 9
) (
    input  logic                     clk,
    input  logic                     wen,
    input  logic [ADDR_W-1:0]        waddr,
    input  logic [NBYTES-1:0]        wbe,
    input  logic [NBYTES*BYTE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]        raddr,
    output logic [NBYTES*BYTE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_mem [DEPTH];

        // Commit this lane when the write is enabled for it.
        always_ff @(posedge clk) begin
            if (wen && wbe[g]) begin
                lane_mem[waddr] <= wdata[g*BYTE_W +: BYTE_W];
            end
        end

        assign rdata[g*BYTE_W +: BYTE_W] = lane_mem[raddr];
    end

endmodule

// File: rtl/lwsram_rdpath.sv
`timescale 1ns/1ps
// lwsram_rdpath: read data path.
// In registered-output mode it merges the array word with the pending
// write of stage 1 (whose data is on din now) and registers the result.
// In flow-through mode it passes the array word straight out.
// Output enable and sleep gate the drive without a clock.
module lwsram_rdpath #(
    parameter int ADDR_W = 5,
    parameter int NBYTES = 2,
    parameter int BYTE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flow_thru,
    input  logic                     out_en_n,
    input  logic                     sleep_req,
    input  logic                     s1_v,
    input  logic                     s1_wr,
    input  logic [ADDR_W-1:0]        s1_addr,
    input  logic                     s2_v,
    input  logic                     s2_wr,
    input  logic [ADDR_W-1:0]        s2_addr,
    input  logic [NBYTES-1:0]        s2_be,
    input  logic [NBYTES*BYTE_W-1:0] din,
    input  logic [NBYTES*BYTE_W-1:0] arr_rdata,
    output logic [NBYTES*BYTE_W-1:0] dout,
    output logic                     dout_drv
);

    localparam int DW = NBYTES * BYTE_W;

    logic          s1_rd;
    logic          fwd_hit;
    logic [DW-1:0] merged;
    logic [DW-1:0] out_q;
    logic          out_v;
    logic [DW-1:0] data_sel;
    logic          drv_ok;

    assign s1_rd   = s1_v & ~s1_wr;
    assign fwd_hit = ~flow_thru & s2_v & s2_wr & (s2_addr == s1_addr);

    for (genvar g = 0; g < NBYTES; g++) begin : g_merge
        assign merged[g*BYTE_W +: BYTE_W] = (fwd_hit && s2_be[g]) ?
            din[g*BYTE_W +: BYTE_W] : arr_rdata[g*BYTE_W +: BYTE_W];
    end

    // Output register for registered-output mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_v <= 1'b0;
            out_q <= '0;
        end else begin
            out_v <= s1_rd;
            if (s1_rd) begin
                out_q <= merged;
            end
        end
    end

    assign data_sel = flow_thru ? arr_rdata : out_q;
    assign drv_ok   = (flow_thru ? s1_rd : out_v) & ~out_en_n & ~sleep_req;
    assign dout     = drv_ok ? data_sel : '0;
    assign dout_drv = drv_ok;

endmodule

// File: rtl/lwsram.sv
`timescale 1ns/1ps
// lwsram: late-write synchronous SRAM with zero bus turnaround.
// The command decode feeds a two-stage command pipe. A write commits when
// its data arrives: from stage 0 in flow-through mode, stage 1 otherwise.
// Reads address the array from stage 0.
// Assumes flow_thru and order_xor change only while in reset.
module lwsram #(
    parameter int ADDR_W = 5,
    parameter int NBYTES = 2,
    parameter int BYTE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flow_thru,
    input  logic                     order_xor,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     wr_n,
    input  logic [NBYTES-1:0]        byte_wr_n,
    input  logic                     sel_a_n,
    input  logic                     sel_b,
    input  logic                     sel_c_n,
    input  logic                     burst_step,
    input  logic                     out_en_n,
    input  logic                     sleep_req,
    input  logic [NBYTES*BYTE_W-1:0] din,
    output logic [NBYTES*BYTE_W-1:0] dout,
    output logic                     dout_drv
);

    localparam int DW     = NBYTES * BYTE_W;
    localparam int STAGES = 2;

    logic              cmd_v;
    logic              cmd_wr;
    logic [ADDR_W-1:0] cmd_addr;
    logic [NBYTES-1:0] cmd_be;

    logic [STAGES-1:0]             st_v;
    logic [STAGES-1:0]             st_wr;
    logic [STAGES-1:0][ADDR_W-1:0] st_addr;
    logic [STAGES-1:0][NBYTES-1:0] st_be;

    logic              rd_acc;
    logic              s1_valid;
    logic              w_sel;
    logic              w_en;
    logic [ADDR_W-1:0] w_addr;
    logic [NBYTES-1:0] w_be;
    logic [DW-1:0]     arr_rdata;

    lwsram_cmd #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_req  (sleep_req),
        .order_xor  (order_xor),
        .addr       (addr),
        .wr_n       (wr_n),
        .byte_wr_n  (byte_wr_n),
        .sel_a_n    (sel_a_n),
        .sel_b      (sel_b),
        .sel_c_n    (sel_c_n),
        .burst_step (burst_step),
        .cmd_v      (cmd_v),
        .cmd_wr     (cmd_wr),
        .cmd_addr   (cmd_addr),
        .cmd_be     (cmd_be)
    );

    lwsram_stages #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .STAGES(STAGES)) u_stages (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_v    (cmd_v),
        .in_wr   (cmd_wr),
        .in_addr (cmd_addr),
        .in_be   (cmd_be),
        .st_v    (st_v),
        .st_wr   (st_wr),
        .st_addr (st_addr),
        .st_be   (st_be)
    );

    assign rd_acc   = cmd_v & ~cmd_wr;
    assign s1_valid = st_v[0];

    // Pick the stage whose write data is on din this cycle.
    assign w_sel  = ~flow_thru;
    assign w_en   = st_v[w_sel] & st_wr[w_sel];
    assign w_addr = st_addr[w_sel];
    assign w_be   = st_be[w_sel];

    lwsram_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_array (
        .clk   (clk),
        .wen   (w_en),
        .waddr (w_addr),
        .wbe   (w_be),
        .wdata (din),
        .raddr (st_addr[0]),
        .rdata (arr_rdata)
    );

    lwsram_rdpath #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_rdpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .flow_thru (flow_thru),
        .out_en_n  (out_en_n),
        .sleep_req (sleep_req),
        .s1_v      (st_v[0]),
        .s1_wr     (st_wr[0]),
        .s1_addr   (st_addr[0]),
        .s2_v      (st_v[1]),
        .s2_wr     (st_wr[1]),
        .s2_addr   (st_addr[1]),
        .s2_be     (st_be[1]),
        .din       (din),
        .arr_rdata (arr_rdata),
        .dout      (dout),
        .dout_drv  (dout_drv)
    );

endmodule

// File: rtl/lwsram_chk.sv
`timescale 1ns/1ps
// lwsram_chk: protocol assertions for lwsram, attached by bind.
// Relates accepted reads, the first pipeline stage and the output pins.
module lwsram_chk #(
    parameter int DW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flow_thru,
    input logic          burst_step,
    input logic          sel_a_n,
    input logic          sel_b,
    input logic          sel_c_n,
    input logic          out_en_n,
    input logic          sleep_req,
    input logic          rd_acc,
    input logic          s1_valid,
    input logic [DW-1:0] dout,
    input logic          dout_drv
);

    AST_PIPE_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow_thru && rd_acc) |-> ##2 (dout_drv || out_en_n || sleep_req)); // R1

    AST_FLOW_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_thru && rd_acc) |=> (dout_drv || out_en_n || sleep_req)); // R2

    AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_step && !sleep_req && !(!sel_a_n && sel_b && !sel_c_n)) |=> !s1_valid); // R6

    AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> (!dout_drv && dout == '0)); // R10

    AST_SLEEP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |=> !s1_valid); // R11

endmodule

bind lwsram lwsram_chk #(.DW(NBYTES*BYTE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flow_thru  (flow_thru),
    .burst_step (burst_step),
    .sel_a_n    (sel_a_n),
    .sel_b      (sel_b),
    .sel_c_n    (sel_c_n),
    .out_en_n   (out_en_n),
    .sleep_req  (sleep_req),
    .rd_acc     (rd_acc),
    .s1_valid   (s1_valid),
    .dout       (dout),
    .dout_drv   (dout_drv)
);

// File: tb/sim_lwsram.sv
`timescale 1ns/1ps
// sim_lwsram: scoreboard bench. The driver task models the memory and
// pushes expected output items. A monitor pops and compares them mid-cycle.
module sim_lwsram;

    localparam int AW = 5;
    localparam int NB = 2;
    localparam int DW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flow_thru = 1'b0;
    logic          order_xor = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          wr_n = 1'b1;
    logic [NB-1:0] byte_wr_n = '1;
    logic          sel_a_n = 1'b0;
    logic          sel_b = 1'b0;
    logic          sel_c_n = 1'b0;
    logic          burst_step = 1'b0;
    logic          out_en_n = 1'b0;
    logic          sleep_req = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_drv;

    lwsram #(.ADDR_W(AW), .NBYTES(NB), .BYTE_W(9)) u0 (
        .clk(clk), .rst_n(rst_n), .flow_thru(flow_thru), .order_xor(order_xor),
        .addr(addr), .wr_n(wr_n), .byte_wr_n(byte_wr_n), .sel_a_n(sel_a_n),
        .sel_b(sel_b), .sel_c_n(sel_c_n), .burst_step(burst_step),
        .out_en_n(out_en_n), .sleep_req(sleep_req), .din(din),
        .dout(dout), .dout_drv(dout_drv)
    );

    always #10 clk = ~clk;

    typedef struct {
        int            due;
        logic          en;
        logic [DW-1:0] data;
        string         tag;
    } item_t;

    item_t         sb_q[$];
    logic [DW-1:0] din_plan [int];
    logic [DW-1:0] model [0:(1<<AW)-1];
    int            cyc = 0;
    int            n_chk = 0;
    int            n_bad = 0;
    bit            done = 1'b0;
    bit            want_gap = 1'b0;
    bit            b_act = 1'b0;
    bit            b_wr = 1'b0;
    logic [AW-1:0] b_base = '0;
    logic [1:0]    b_cnt = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic push(input int due, input logic en, input logic [DW-1:0] data, input string tag);
        item_t it;
        it.due = due; it.en = en; it.data = data; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic compare(input string tag, input logic en, input logic [DW-1:0] data);
        n_chk++;
        if (dout_drv !== en || dout !== data) begin
            n_bad++;
            $display("FAIL %s: got drv=%0b data=%h, expected drv=%0b data=%h",
                     tag, dout_drv, dout, en, data);
        end
    endtask

    // Drive din with write data planned for the coming edge.
    initial forever begin
        @(negedge clk);
        if (din_plan.exists(cyc)) din = din_plan[cyc];
        else din = '0;
    end

    // Monitor: sample 5 ns after the falling edge and compare due items.
    initial forever begin
        @(negedge clk);
        #5;
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            item_t it;
            it = sb_q.pop_front();
            if (it.due < cyc) begin
                n_chk++; n_bad++;
                $display("FAIL %s: item for cycle %0d missed, expected data=%h", it.tag, it.due, it.data);
            end else begin
                compare(it.tag, it.en, it.data);
            end
        end
    end

    // One bus cycle. op: 0 idle, 1 load read, 2 load write, 3 burst step.
    task automatic step(input int op, input string tag, input logic [AW-1:0] a = '0,
                        input logic [NB-1:0] bwn = '0, input logic [DW-1:0] d = '0,
                        input bit csel = 1'b1, input bit exp_on = 1'b1,
                        input bit oe_hi = 1'b0, input bit slp = 1'b0);
        int e, dd;
        logic [AW-1:0] ea;
        bit act, wr;
        @(negedge clk);
        e  = cyc + 1;
        dd = flow_thru ? e : e + 1;
        out_en_n = oe_hi; sleep_req = slp;
        sel_a_n = 1'b0; sel_c_n = 1'b0; sel_b = csel;
        burst_step = (op == 3); wr_n = (op != 2); addr = a; byte_wr_n = bwn;
        act = 1'b0; wr = 1'b0; ea = a;
        if (slp) begin
            b_act = 1'b0;
        end else if (op == 0) begin
            sel_b = 1'b0; b_act = 1'b0;
        end else if (op == 1 || op == 2) begin
            if (csel) begin
                b_act = 1'b1; b_wr = (op == 2); b_base = a; b_cnt = '0;
                act = 1'b1; wr = (op == 2);
            end else begin
                b_act = 1'b0;
                if (op == 1) push(dd, 1'b0, '0, tag);
            end
        end else if (b_act) begin
            b_cnt = b_cnt + 2'd1;
            ea = {b_base[AW-1:2], order_xor ? (b_base[1:0] ^ b_cnt) : (b_base[1:0] + b_cnt)};
            act = 1'b1; wr = b_wr;
        end
        if (act && wr) begin
            din_plan[e + (flow_thru ? 0 : 1)] = d;
            for (int i = 0; i < NB; i++)
                if (!bwn[i]) model[ea][i*9 +: 9] = d[i*9 +: 9];
        end
        if (act && !wr) begin
            if (want_gap) begin
                push(dd - 1, 1'b0, '0, tag);
                want_gap = 1'b0;
            end
            push(dd, exp_on, exp_on ? model[ea] : '0, tag);
        end
    endtask

    // Read whose due cycle is covered by output disable or sleep.
    task automatic masked(input logic [AW-1:0] a, input bit use_sleep, input string tag);
        step(1, tag, a, '0, '0, 1'b1, 1'b0);
        if (!flow_thru) step(0, tag);
        step(0, tag, '0, '0, '0, 1'b1, 1'b1, !use_sleep, use_sleep);
        step(0, tag);
    endtask

    task automatic run_suite();
        string lt, ord;
        lt  = flow_thru ? "R2 flow latency" : "R1 pipe latency";
        ord = order_xor ? "R9 xor order" : "R8 linear order";
        step(2, "R3 write a1", 1, 2'b00, 18'h12345);
        step(2, "R3 write a2", 2, 2'b00, 18'h2B0B0);
        step(2, "R3 write a5", 5, 2'b00, 18'h05555);
        step(1, lt, 1);
        step(1, lt, 2);
        step(0, lt); step(0, lt);
        want_gap = 1'b1;
        step(1, lt, 5);
        step(2, "R5 lane0 write", 5, 2'b10, 18'h3FFFF);
        step(1, "R4 read pending merge", 5);
        step(2, "R5 lane1 write", 5, 2'b01, 18'h00000);
        step(1, "R4 read pending lane1", 5);
        step(1, "R5 lanes kept", 5);
        step(2, "R4 w a7", 7, 2'b00, 18'h17777);
        step(1, "R4 r a7", 7);
        step(2, "R4 w a8", 8, 2'b00, 18'h08888);
        step(1, "R4 r a8", 8);
        step(1, "R4 r a7 again", 7);
        step(2, "R6 deselected write", 1, 2'b00, 18'h30303, 1'b0);
        step(3, "R7 step after deselect", 0, 2'b00, 18'h3AAAA);
        step(1, "R6 deselected read", 1, 2'b00, '0, 1'b0);
        step(1, "R6 word unchanged", 1);
        step(2, ord, 5, 2'b00, 18'h10001);
        step(3, ord, 0, 2'b00, 18'h10002);
        step(3, ord, 0, 2'b00, 18'h10003);
        step(3, ord, 0, 2'b00, 18'h10004);
        for (int i = 4; i < 8; i++) step(1, ord, i[AW-1:0]);
        step(1, "R7 burst read", 7);
        step(3, "R7 burst read", 0);
        step(3, "R7 burst read", 0);
        step(3, "R7 burst read", 0);
        masked(6, 1'b0, "R10 output disabled");
        masked(6, 1'b1, "R11 sleep undriven");
        step(2, "R11 write in sleep", 6, 2'b00, 18'h22222, 1'b1, 1'b1, 1'b0, 1'b1);
        step(1, "R11 write ignored", 6);
        repeat (4) step(0, "drain");
    endtask

    task automatic do_reset(input bit ft, input bit ox);
        @(negedge clk);
        rst_n = 1'b0; flow_thru = ft; order_xor = ox;
        sel_b = 1'b0; burst_step = 1'b0;
        repeat (3) @(negedge clk);
        #5;
        compare("R12 reset undriven", 1'b0, '0);
        @(negedge clk);
        rst_n = 1'b1;
        b_act = 1'b0;
    endtask

    initial begin
        do_reset(1'b0, 1'b0);
        run_suite();
        do_reset(1'b1, 1'b1);
        step(1, "R12 contents retained", 1);
        step(0, "R12");
        run_suite();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got no completion, expected end of run");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule